// File: doc/BRIEF.md
# Scan-Chain Test Wrapper with Pattern Sequencer

This block wraps a small example design, a bank of four 4-bit lane registers and the combinational logic that feeds them, so that every state bit sits in one serial test chain. In front of each flop is a two-way selector. With shifting off, the flop loads its functional next value. With shifting on, it loads the output of its neighbour nearer the serial input. Held in functional mode, the wrapped design behaves exactly like the bare one.

A built-in sequencer runs the complete test procedure. It shifts a 16-bit stimulus into the chain, gives one functional clock that captures the logic's outputs, and then streams that response out. While the response streams out, the next stimulus streams in behind it. Each outgoing bit is compared with an expected vector. When a response has been fully examined, the sequencer raises a one-cycle completion strobe and a match flag. While the sequencer is idle, the external shift control and serial input own the chain.

Top module: `scan_wrap`

## Requirements
- R1: While `rst` is high at a clock edge, all chain flops, `seq_busy`, `seq_done` and `seq_pass` become 0 after that edge.
- R2: With the sequencer idle and `scan_en` low, each lane i (bits 4i+3..4i of `state_out`) loads lane ((i+1) mod 4) plus (lane i XOR `func_in`), modulo 16.
- R3: With the sequencer idle and `scan_en` high, flop 0 loads `scan_in`, flop k loads flop k-1, and `scan_out` always shows flop 15.
- R4: After `seq_start` is taken while idle, the sequencer shifts for exactly 16 edges, sending bit 15 of the pattern first, so that `state_out` then equals the pattern.
- R5: Directly after a 16-edge load comes exactly one functional capture edge, which applies the R2 rule using `func_in`.
- R6: If `seq_start` is high during the capture cycle, the new pattern is shifted in over the same 16 edges that shift the captured response out.
- R7: `seq_done` pulses for one cycle after every shift phase that carried a response out. `seq_pass` is then 1 exactly when the response equals the expected vector given with its stimulus, and it holds until the next pulse.
- R8: With no `seq_start` in the capture cycle, the sequencer unloads by shifting in zeros, returns to idle, and leaves the chain all zero.
- R9: While `seq_busy` is high, `scan_en` and `scan_in` have no effect, and `seq_start` has no effect outside the capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_in | input | 4 | Functional input to the example logic |
| state_out | output | 16 | Contents of the chain flops |
| scan_en | input | 1 | External shift control, used while idle |
| scan_in | input | 1 | External serial input, used while idle |
| scan_out | output | 1 | Serial output, the last chain flop |
| seq_start | input | 1 | Begin a run, or supply the next pattern during capture |
| seq_pattern | input | 16 | Stimulus to load |
| seq_expect | input | 16 | Expected response for that stimulus |
| seq_busy | output | 1 | Sequencer owns the chain |
| seq_done | output | 1 | One-cycle strobe after a response is examined |
| seq_pass | output | 1 | Result of the last examined response |

## Verification
The sharpest overlap comes during chained runs. A single shift phase both unloads and judges the previous response and loads the next stimulus, so a fault in either half shows up in the other. The bench raises `seq_start` exactly in the capture cycle, and for the second pattern it deliberately supplies a wrong expected vector. A mis-ordered shift or an off-by-one compare would then flip the pass flag of the wrong run. A behavioural model follows every edge and is compared with `state_out`, `scan_out` and the flags, and the per-run pass results are checked against a list of expected outcomes.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_CAPT  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst,
  input  logic shift,
  input  logic d_func,
  input  logic d_scan,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= shift ? d_scan : d_func;
  end
endmodule

// File: rtl/demo_logic.sv
module demo_logic #(
  parameter int LANE_W = 4,
  parameter int LANES  = 4
) (
  input  logic [LANE_W*LANES-1:0] st,
  input  logic [LANE_W-1:0]       din,
  output logic [LANE_W*LANES-1:0] nxt
);
  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      localparam int NB = (i + 1) % LANES;
      assign nxt[i*LANE_W +: LANE_W] = st[NB*LANE_W +: LANE_W] + (st[i*LANE_W +: LANE_W] ^ din);
    end
  endgenerate
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int CHAIN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CHAIN-1:0] pattern,
  input  logic [CHAIN-1:0] expect_v,
  input  logic             so,
  output logic             shift_o,
  output logic             si_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o
);
  localparam int CW = (CHAIN > 1) ? $clog2(CHAIN) : 1;

  sq_state_t        state;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    idx;
  logic [CHAIN-1:0] pat_q, exp_now, exp_next;
  logic             armed, last, acc, bit_bad;

  assign idx     = CW'(CHAIN - 1) - cnt;
  assign si_o    = pat_q[idx];
  assign bit_bad = armed & (so != exp_now[idx]);
  assign shift_o = (state == SQ_SHIFT);
  assign busy_o  = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      pat_q    <= '0;
      exp_now  <= '0;
      exp_next <= '0;
      armed    <= 1'b0;
      last     <= 1'b0;
      acc      <= 1'b0;
      done_o   <= 1'b0;
      pass_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            pat_q    <= pattern;
            exp_next <= expect_v;
            armed    <= 1'b0;
            last     <= 1'b0;
            cnt      <= '0;
            acc      <= 1'b0;
            state    <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: begin
          acc <= acc | bit_bad;
          if (cnt == CW'(CHAIN - 1)) begin
            cnt    <= '0;
            done_o <= armed;
            if (armed) pass_o <= ~(acc | bit_bad);
            state  <= last ? SQ_IDLE : SQ_CAPT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_CAPT: begin
          armed   <= 1'b1;
          exp_now <= exp_next;
          acc     <= 1'b0;
          state   <= SQ_SHIFT;
          if (start) begin
            pat_q    <= pattern;
            exp_next <= expect_v;
            last     <= 1'b0;
          end else begin
            pat_q <= '0;
            last  <= 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_wrap.sv
module scan_wrap #(
  parameter int LANE_W = 4,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANE_W-1:0]        func_in,
  output logic [LANE_W*LANES-1:0]  state_out,
  input  logic                     scan_en,
  input  logic                     scan_in,
  output logic                     scan_out,
  input  logic                     seq_start,
  input  logic [LANE_W*LANES-1:0]  seq_pattern,
  input  logic [LANE_W*LANES-1:0]  seq_expect,
  output logic                     seq_busy,
  output logic                     seq_done,
  output logic                     seq_pass
);
  localparam int CHAIN = LANE_W * LANES;

  logic [CHAIN-1:0] chain_q, func_nxt;
  logic             chain_shift, chain_si, sq_shift, sq_si;

  demo_logic #(.LANE_W(LANE_W), .LANES(LANES)) u_logic (
    .st(chain_q), .din(func_in), .nxt(func_nxt)
  );

  scan_sequencer #(.CHAIN(CHAIN)) u_seq (
    .clk(clk), .rst(rst), .start(seq_start), .pattern(seq_pattern),
    .expect_v(seq_expect), .so(chain_q[CHAIN-1]), .shift_o(sq_shift),
    .si_o(sq_si), .busy_o(seq_busy), .done_o(seq_done), .pass_o(seq_pass)
  );

  assign chain_shift = seq_busy ? sq_shift : scan_en;
  assign chain_si    = seq_busy ? sq_si    : scan_in;

  genvar k;
  generate
    for (k = 0; k < CHAIN; k++) begin : g_cell
      if (k == 0) begin : g_head
        scan_cell u_cell (
          .clk(clk), .rst(rst), .shift(chain_shift), .d_func(func_nxt[k]),
          .d_scan(chain_si), .q(chain_q[k])
        );
      end else begin : g_body
        scan_cell u_cell (
          .clk(clk), .rst(rst), .shift(chain_shift), .d_func(func_nxt[k]),
          .d_scan(chain_q[k-1]), .q(chain_q[k])
        );
      end
    end
  endgenerate

  assign state_out = chain_q;
  assign scan_out  = chain_q[CHAIN-1];
endmodule

// File: rtl/scan_wrap_chk.sv
module scan_wrap_chk #(
  parameter int CHAIN = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             chain_shift,
  input logic             chain_si,
  input logic [CHAIN-1:0] chain_q,
  input logic             seq_busy,
  input logic             seq_done,
  input logic             seq_pass
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      AST_RESET_CLEAR: assert (chain_q == '0 && !seq_busy && !seq_done && !seq_pass); // R1
    end
  end

  AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    chain_shift |=> chain_q[CHAIN-1:1] == $past(chain_q[CHAIN-2:0])); // R3
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    chain_shift |=> chain_q[0] == $past(chain_si)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done); // R7
  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> $past(seq_busy)); // R7
  AST_PASS_HELD: assert property (@(posedge clk) disable iff (rst)
    !seq_done |-> $stable(seq_pass)); // R7
endmodule

bind scan_wrap scan_wrap_chk #(.CHAIN(LANE_W*LANES)) u_chk (
  .clk(clk), .rst(rst), .chain_shift(chain_shift), .chain_si(chain_si),
  .chain_q(chain_q), .seq_busy(seq_busy), .seq_done(seq_done), .seq_pass(seq_pass)
);

// File: tb/sim_scan_wrap.sv
`timescale 1ns/1ps
module sim_scan_wrap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  func_in = '0;
  logic [15:0] state_out;
  logic        scan_en = 1'b0, scan_in = 1'b0, scan_out;
  logic        seq_start = 1'b0;
  logic [15:0] seq_pattern = '0, seq_expect = '0;
  logic        seq_busy, seq_done, seq_pass;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  scan_wrap u0 (
    .clk(clk), .rst(rst), .func_in(func_in), .state_out(state_out),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
    .seq_start(seq_start), .seq_pattern(seq_pattern), .seq_expect(seq_expect),
    .seq_busy(seq_busy), .seq_done(seq_done), .seq_pass(seq_pass)
  );

  function automatic logic [15:0] ref_f(input logic [15:0] s, input logic [3:0] d);
    logic [15:0] r;
    for (int i = 0; i < 4; i++)
      r[4*i +: 4] = s[4*((i+1)%4) +: 4] + (s[4*i +: 4] ^ d);
    return r;
  endfunction

  // behavioural reference model: 0 idle, 1 shifting, 2 capture
  logic [15:0] m_q = '0, m_pat = '0, m_resp = '0, m_cmp = '0, m_nexp = '0;
  int          m_st = 0, m_cnt = 0;
  bit          m_armed = 0, m_last = 0, m_done = 0, m_pass = 0;
  string       m_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_q = '0; m_st = 0; m_cnt = 0; m_armed = 0; m_last = 0;
      m_done = 0; m_pass = 0; m_tag = "R1";
    end else begin
      m_done = 0;
      case (m_st)
        0: begin
          if (scan_en) begin m_q = {m_q[14:0], scan_in}; m_tag = "R3"; end
          else begin m_q = ref_f(m_q, func_in); m_tag = "R2"; end
          if (seq_start) begin
            m_pat = seq_pattern; m_nexp = seq_expect;
            m_armed = 0; m_last = 0; m_cnt = 0; m_st = 1;
          end
        end
        1: begin
          m_q = {m_q[14:0], m_pat[15-m_cnt]};
          m_tag = m_last ? "R8" : (m_armed ? "R6" : "R4");
          if (scan_en || seq_start) m_tag = "R9";
          if (m_cnt == 15) begin
            m_done = m_armed;
            if (m_armed) m_pass = (m_resp == m_cmp);
            m_st = m_last ? 0 : 2;
            m_cnt = 0;
          end else m_cnt++;
        end
        default: begin
          m_q = ref_f(m_q, func_in);
          m_tag = scan_en ? "R9" : "R5";
          m_resp = m_q; m_armed = 1; m_cmp = m_nexp; m_st = 1;
          if (seq_start) begin m_pat = seq_pattern; m_nexp = seq_expect; m_last = 0; end
          else begin m_pat = '0; m_last = 1; end
        end
      endcase
    end
  end

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    chk(m_tag, "state_out", state_out, m_q);
    chk(m_tag, "scan_out", 16'(scan_out), 16'(m_q[15]));
    chk(m_tag, "seq_busy", 16'(seq_busy), 16'(m_st != 0));
    chk("R7", "seq_done", 16'(seq_done), 16'(m_done));
    chk("R7", "seq_pass", 16'(seq_pass), 16'(m_pass));
  end

  bit exp_pass[$];
  int done_seen = 0;
  always @(negedge clk) begin
    if (!rst && seq_done) begin
      done_seen++;
      if (exp_pass.size() > 0) chk("R7", "run verdict", 16'(seq_pass), 16'(exp_pass.pop_front()));
      else chk("R7", "unexpected done", 16'd1, 16'd0);
    end
  end

  task automatic wait_st(input int s);
    do @(negedge clk); while (m_st != s);
  endtask

  task automatic go(input logic [15:0] p, input logic [15:0] e);
    seq_start = 1'b1; seq_pattern = p; seq_expect = e;
    @(negedge clk);
    seq_start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset chain", state_out, 16'h0000);
    chk("R1", "reset flags", {13'd0, seq_busy, seq_done, seq_pass}, 16'h0000);
    rst = 1'b0;
    // R2: free-running functional mode
    for (int i = 0; i < 12; i++) begin func_in = 4'(i * 3 + 1); @(negedge clk); end
    // R3: external shifting
    scan_en = 1'b1;
    for (int i = 0; i < 20; i++) begin scan_in = ((20'hA5C3F >> i) & 1) != 0; @(negedge clk); end
    scan_en = 1'b0;
    // run 1: correct expectation, chained run 2 with wrong expectation (R4, R5, R6, R7, R9)
    func_in = 4'h6;
    exp_pass.push_back(1'b1);
    exp_pass.push_back(1'b0);
    go(16'h1234, ref_f(16'h1234, 4'h6));
    repeat (4) @(negedge clk);
    scan_en = 1'b1; scan_in = 1'b1; seq_start = 1'b1; seq_pattern = 16'hDEAD;
    @(negedge clk);
    scan_en = 1'b0; scan_in = 1'b0; seq_start = 1'b0;
    wait_st(2);
    chk("R4", "loaded pattern", state_out, 16'h1234);
    go(16'hBEEF, ref_f(16'hBEEF, 4'h6) ^ 16'h0010);
    chk("R5", "captured response", state_out, ref_f(16'h1234, 4'h6));
    wait_st(2);
    chk("R6", "second pattern loaded", state_out, 16'hBEEF);
    @(negedge clk);
    wait_st(0);
    chk("R8", "chain cleared after unload", state_out, 16'h0000);
    // run 3 and 4: unloads with extreme patterns
    func_in = 4'hF;
    exp_pass.push_back(1'b1);
    go(16'hFFFF, ref_f(16'hFFFF, 4'hF));
    wait_st(0);
    func_in = 4'h9;
    exp_pass.push_back(1'b1);
    go(16'h0000, ref_f(16'h0000, 4'h9));
    wait_st(0);
    repeat (4) @(negedge clk);
    chk("R7", "verdict count", 16'(done_seen), 16'd4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule